// File: doc/BRIEF.md
# Rename History Log with Commit and Squash Recovery

This block keeps an ordered log of register rename decisions made speculatively by a rename stage. Every renamed destination adds one entry that holds the instruction's sequence number, its architectural register, the physical register it was given and the physical register that held that architectural register before. An instruction with no destination adds a single marker entry so that its sequence number still has a place in the log. The rename table and the free list live outside. This block only maintains the log and hands registers back.

When instructions retire, a commit walk drains the log from the oldest end and gives back each displaced (previous) physical register. When a mispredict or fault squashes younger work, a squash walk drains the log from the youngest end. For each real entry it tells the rename table to map the architectural register back to its previous physical register, and it gives the newly assigned register back. Both walks take one entry per clock. At most one register leaves on the free-list port in any cycle. Four event counters track committed maps, undone entries, undone real entries and inserted markers.

Top module: `rename_history_buf`

## Requirements
- R1: After reset the log is empty, `busy`, `free_valid` and `restore_valid` are low, `insert_ready` is high and all four counters read zero.
- R2: An insert is taken at a rising edge when `insert_ready` is high. A real entry is taken when `alloc_valid` is high. A marker entry is taken when `hold_valid` is high and `alloc_valid` is low. `insert_ready` is high only while no walk is running and the log holds fewer than DEPTH entries.
- R3: With DEPTH entries held, `insert_ready` is low and a request to insert leaves the log unchanged.
- R4: A commit request from idle starts a walk in the next cycle. Each walk cycle removes the oldest entry if its sequence number is less than or equal to the done number. A removed real entry drives `free_valid` with its previous physical register. The walk ends in the first cycle that removes nothing, and `busy` falls one cycle later.
- R5: A squash request starts a walk in the next cycle. Each walk cycle removes the youngest entry if its sequence number is greater than the squash number. A removed real entry drives `restore_valid` with its architectural register and previous physical register, and in the same cycle drives `free_valid` with its new physical register.
- R6: Removing a marker entry, by commit or by squash, drives neither `free_valid` nor `restore_valid`.
- R7: A commit request that arrives while a walk is running is dropped. A squash request wins over a commit request in the same idle cycle. A squash request during a commit walk ends that walk after its current removal, and the squash walk starts in the next cycle.
- R8: `busy` is high in every cycle a walk is running. No register is returned while `busy` is low.
- R9: `cnt_commit_maps` counts real entries removed by commit. `cnt_undo_maps` counts all entries removed by squash. `cnt_undo_real` counts real entries removed by squash. `cnt_holds` counts marker entries inserted.
- R10: A walk stops when the log is empty and never removes an entry from an empty log.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Insert a real rename entry |
| alloc_seq | input | SEQ_W | Sequence number of the renamed instruction |
| alloc_areg | input | AREG_W | Architectural destination |
| alloc_new_preg | input | PREG_W | Physical register newly assigned |
| alloc_old_preg | input | PREG_W | Physical register mapped before |
| hold_valid | input | 1 | Insert a marker entry for an instruction without destination |
| hold_seq | input | SEQ_W | Sequence number of the marker |
| insert_ready | output | 1 | Log can take an insert this cycle |
| commit_valid | input | 1 | Retire up to and including `commit_seq` |
| commit_seq | input | SEQ_W | Done sequence number |
| squash_valid | input | 1 | Undo everything younger than `squash_seq` |
| squash_seq | input | SEQ_W | Squash sequence number |
| free_valid | output | 1 | A physical register is returned |
| free_preg | output | PREG_W | Returned physical register |
| restore_valid | output | 1 | Rename table entry must be rewritten |
| restore_areg | output | AREG_W | Architectural register to rewrite |
| restore_preg | output | PREG_W | Physical register to map it back to |
| busy | output | 1 | A walk is running |
| log_full | output | 1 | Log holds DEPTH entries |
| log_empty | output | 1 | Log holds no entries |
| cnt_commit_maps | output | CNT_W | Real entries removed by commit |
| cnt_undo_maps | output | CNT_W | Entries removed by squash |
| cnt_undo_real | output | CNT_W | Real entries removed by squash |
| cnt_holds | output | CNT_W | Marker entries inserted |

## Verification
The bench targets these corner cases:
- a commit whose done number sits between two entries, where a design that compared with strict inequality would leave the matching entry behind;
- markers mixed among real entries, where a design that did not honour the marker flag would hand out bogus register numbers;
- a log filled to DEPTH, plus walks that drain it to empty, where broken pointer wrap or a missing empty check would return stale entries or run forever;
- a commit dropped during a squash, and a squash landing mid-commit, where wrong arbitration would retire entries that were meant to be undone;
- per-cycle checks of which register appears on which port, which catch a squash that returned the previous register instead of the new one.

// File: rtl/rhb_pkg.sv
package rhb_pkg;

  typedef enum logic [1:0] {
    WK_IDLE   = 2'd0,
    WK_COMMIT = 2'd1,
    WK_SQUASH = 2'd2
  } walk_e;

  // entry retires under a done number when it is not younger
  function automatic logic seq_retires(logic [31:0] s, logic [31:0] lim);
    return s <= lim;
  endfunction

  // entry is undone by a squash number when it is strictly younger
  function automatic logic seq_undone(logic [31:0] s, logic [31:0] lim);
    return s > lim;
  endfunction

  function automatic int unsigned ptr_inc(int unsigned p, int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  function automatic int unsigned ptr_dec(int unsigned p, int unsigned depth);
    return (p == 0) ? depth - 1 : p - 1;
  endfunction

endpackage

// File: rtl/rhb_store.sv
module rhb_store #(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 16,
  parameter int AREG_W = 5,
  parameter int PREG_W = 6,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [SEQ_W-1:0]  push_seq,
  input  logic [AREG_W-1:0] push_areg,
  input  logic [PREG_W-1:0] push_newp,
  input  logic [PREG_W-1:0] push_oldp,
  input  logic              push_ph,
  input  logic              pop_old,
  input  logic              pop_young,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  count,
  output logic [SEQ_W-1:0]  old_seq,
  output logic              old_ph,
  output logic [PREG_W-1:0] old_oldp,
  output logic [SEQ_W-1:0]  yng_seq,
  output logic              yng_ph,
  output logic [AREG_W-1:0] yng_areg,
  output logic [PREG_W-1:0] yng_newp,
  output logic [PREG_W-1:0] yng_oldp
);
  import rhb_pkg::*;

  logic [SEQ_W-1:0]  seq_mem  [DEPTH];
  logic [AREG_W-1:0] areg_mem [DEPTH];
  logic [PREG_W-1:0] newp_mem [DEPTH];
  logic [PREG_W-1:0] oldp_mem [DEPTH];
  logic              ph_mem   [DEPTH];

  logic [PTR_W-1:0] head_q, tail_q, yng_ptr;
  logic [CNT_W-1:0] cnt_q;

  assign yng_ptr = PTR_W'(ptr_dec(32'(tail_q), DEPTH));
  assign count   = cnt_q;
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);

  assign old_seq  = seq_mem[head_q];
  assign old_ph   = ph_mem[head_q];
  assign old_oldp = oldp_mem[head_q];
  assign yng_seq  = seq_mem[yng_ptr];
  assign yng_ph   = ph_mem[yng_ptr];
  assign yng_areg = areg_mem[yng_ptr];
  assign yng_newp = newp_mem[yng_ptr];
  assign yng_oldp = oldp_mem[yng_ptr];

  always_ff @(posedge clk) begin
    if (push) begin
      seq_mem[tail_q]  <= push_seq;
      areg_mem[tail_q] <= push_areg;
      newp_mem[tail_q] <= push_newp;
      oldp_mem[tail_q] <= push_oldp;
      ph_mem[tail_q]   <= push_ph;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push)
        tail_q <= PTR_W'(ptr_inc(32'(tail_q), DEPTH));
      else if (pop_young)
        tail_q <= yng_ptr;
      if (pop_old)
        head_q <= PTR_W'(ptr_inc(32'(head_q), DEPTH));
      case ({push, pop_old | pop_young})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R10
  no_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_old || pop_young) |-> !empty);

  // R10
  one_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop_old && pop_young) && !(push && (pop_old || pop_young)));

endmodule

// File: rtl/rhb_walker.sv
module rhb_walker #(
  parameter int SEQ_W  = 16,
  parameter int AREG_W = 5,
  parameter int PREG_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_valid,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic              squash_valid,
  input  logic [SEQ_W-1:0]  squash_seq,
  input  logic              empty,
  input  logic [SEQ_W-1:0]  old_seq,
  input  logic              old_ph,
  input  logic [PREG_W-1:0] old_oldp,
  input  logic [SEQ_W-1:0]  yng_seq,
  input  logic              yng_ph,
  input  logic [AREG_W-1:0] yng_areg,
  input  logic [PREG_W-1:0] yng_newp,
  input  logic [PREG_W-1:0] yng_oldp,
  output logic              pop_old,
  output logic              pop_young,
  output logic              idle,
  output logic              busy,
  output logic              free_valid,
  output logic [PREG_W-1:0] free_preg,
  output logic              restore_valid,
  output logic [AREG_W-1:0] restore_areg,
  output logic [PREG_W-1:0] restore_preg,
  output logic              ev_commit_map,
  output logic              ev_undo,
  output logic              ev_undo_real
);
  import rhb_pkg::*;

  walk_e            state_q, state_d;
  logic [SEQ_W-1:0] lim_q, lim_d;
  logic             take_old, take_young;

  assign take_old   = !empty && seq_retires(32'(old_seq), 32'(lim_q));
  assign take_young = !empty && seq_undone(32'(yng_seq), 32'(lim_q));

  always_comb begin
    state_d   = state_q;
    lim_d     = lim_q;
    pop_old   = 1'b0;
    pop_young = 1'b0;
    case (state_q)
      WK_IDLE: begin
        if (squash_valid) begin
          state_d = WK_SQUASH;
          lim_d   = squash_seq;
        end else if (commit_valid) begin
          state_d = WK_COMMIT;
          lim_d   = commit_seq;
        end
      end
      WK_COMMIT: begin
        pop_old = take_old;
        if (squash_valid) begin
          state_d = WK_SQUASH;
          lim_d   = squash_seq;
        end else if (!take_old) begin
          state_d = WK_IDLE;
        end
      end
      WK_SQUASH: begin
        pop_young = take_young;
        if (squash_valid)
          lim_d = squash_seq;
        else if (!take_young)
          state_d = WK_IDLE;
      end
      default: state_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WK_IDLE;
      lim_q   <= '0;
    end else begin
      state_q <= state_d;
      lim_q   <= lim_d;
    end
  end

  assign idle          = (state_q == WK_IDLE);
  assign busy          = !idle;
  assign restore_valid = pop_young && !yng_ph;
  assign restore_areg  = yng_areg;
  assign restore_preg  = yng_oldp;
  assign free_valid    = (pop_old && !old_ph) || restore_valid;
  assign free_preg     = pop_young ? yng_newp : old_oldp;
  assign ev_commit_map = pop_old && !old_ph;
  assign ev_undo       = pop_young;
  assign ev_undo_real  = restore_valid;

  // R7
  commit_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WK_SQUASH) |=> (state_q != WK_COMMIT));

  // R8
  free_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_valid |-> busy);

endmodule

// File: rtl/rhb_counters.sv
module rhb_counters #(
  parameter int CNT_W = 16,
  parameter int NUM   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM-1:0]             inc,
  output logic [NUM-1:0][CNT_W-1:0]  val
);
  for (genvar g = 0; g < NUM; g++) begin : g_cnt
    logic [CNT_W-1:0] c_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        c_q <= '0;
      else if (inc[g])
        c_q <= c_q + 1'b1;
    end
    assign val[g] = c_q;
  end
endmodule

// File: rtl/rename_history_buf.sv
module rename_history_buf #(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 16,
  parameter int AREG_W = 5,
  parameter int PREG_W = 6,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [SEQ_W-1:0]  alloc_seq,
  input  logic [AREG_W-1:0] alloc_areg,
  input  logic [PREG_W-1:0] alloc_new_preg,
  input  logic [PREG_W-1:0] alloc_old_preg,
  input  logic              hold_valid,
  input  logic [SEQ_W-1:0]  hold_seq,
  output logic              insert_ready,
  input  logic              commit_valid,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic              squash_valid,
  input  logic [SEQ_W-1:0]  squash_seq,
  output logic              free_valid,
  output logic [PREG_W-1:0] free_preg,
  output logic              restore_valid,
  output logic [AREG_W-1:0] restore_areg,
  output logic [PREG_W-1:0] restore_preg,
  output logic              busy,
  output logic              log_full,
  output logic              log_empty,
  output logic [CNT_W-1:0]  cnt_commit_maps,
  output logic [CNT_W-1:0]  cnt_undo_maps,
  output logic [CNT_W-1:0]  cnt_undo_real,
  output logic [CNT_W-1:0]  cnt_holds
);
  localparam int LCNT_W = $clog2(DEPTH + 1);
  localparam int NUM_EV = 4;

  logic              push, push_ph;
  logic [SEQ_W-1:0]  push_seq;
  logic [AREG_W-1:0] push_areg;
  logic [PREG_W-1:0] push_newp, push_oldp;
  logic              pop_old, pop_young, idle;
  logic              full, empty;
  logic [LCNT_W-1:0] count;
  logic [SEQ_W-1:0]  old_seq, yng_seq;
  logic              old_ph, yng_ph;
  logic [PREG_W-1:0] old_oldp, yng_newp, yng_oldp;
  logic [AREG_W-1:0] yng_areg;
  logic              ev_commit_map, ev_undo, ev_undo_real, ev_hold;
  logic [NUM_EV-1:0]             ev_vec;
  logic [NUM_EV-1:0][CNT_W-1:0]  ev_cnt;

  assign insert_ready = idle && !full;
  assign push         = insert_ready && (alloc_valid || hold_valid);
  assign push_ph      = !alloc_valid;
  assign push_seq     = alloc_valid ? alloc_seq : hold_seq;
  assign push_areg    = alloc_valid ? alloc_areg : '0;
  assign push_newp    = alloc_valid ? alloc_new_preg : '0;
  assign push_oldp    = alloc_valid ? alloc_old_preg : '0;
  assign ev_hold      = push && push_ph;

  rhb_store #(
    .DEPTH(DEPTH), .SEQ_W(SEQ_W), .AREG_W(AREG_W), .PREG_W(PREG_W)
  ) i_store (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_seq(push_seq), .push_areg(push_areg),
    .push_newp(push_newp), .push_oldp(push_oldp), .push_ph(push_ph),
    .pop_old(pop_old), .pop_young(pop_young),
    .full(full), .empty(empty), .count(count),
    .old_seq(old_seq), .old_ph(old_ph), .old_oldp(old_oldp),
    .yng_seq(yng_seq), .yng_ph(yng_ph), .yng_areg(yng_areg),
    .yng_newp(yng_newp), .yng_oldp(yng_oldp)
  );

  rhb_walker #(
    .SEQ_W(SEQ_W), .AREG_W(AREG_W), .PREG_W(PREG_W)
  ) i_walker (
    .clk(clk), .rst_n(rst_n),
    .commit_valid(commit_valid), .commit_seq(commit_seq),
    .squash_valid(squash_valid), .squash_seq(squash_seq),
    .empty(empty),
    .old_seq(old_seq), .old_ph(old_ph), .old_oldp(old_oldp),
    .yng_seq(yng_seq), .yng_ph(yng_ph), .yng_areg(yng_areg),
    .yng_newp(yng_newp), .yng_oldp(yng_oldp),
    .pop_old(pop_old), .pop_young(pop_young), .idle(idle), .busy(busy),
    .free_valid(free_valid), .free_preg(free_preg),
    .restore_valid(restore_valid), .restore_areg(restore_areg),
    .restore_preg(restore_preg),
    .ev_commit_map(ev_commit_map), .ev_undo(ev_undo),
    .ev_undo_real(ev_undo_real)
  );

  assign ev_vec = {ev_hold, ev_undo_real, ev_undo, ev_commit_map};

  rhb_counters #(.CNT_W(CNT_W), .NUM(NUM_EV)) i_counters (
    .clk(clk), .rst_n(rst_n), .inc(ev_vec), .val(ev_cnt)
  );

  assign cnt_commit_maps = ev_cnt[0];
  assign cnt_undo_maps   = ev_cnt[1];
  assign cnt_undo_real   = ev_cnt[2];
  assign cnt_holds       = ev_cnt[3];
  assign log_full        = full;
  assign log_empty       = empty;

  // R2
  push_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !busy);

  // R5
  restore_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid |=> count == LCNT_W'($past(count) - 1'b1));

endmodule

// File: tb/test_rename_history_buf.sv
`timescale 1ns/1ps
module test_rename_history_buf;
  localparam int DEPTH = 8, SEQ_W = 16, AREG_W = 5, PREG_W = 6, CNT_W = 16;

  typedef struct {
    int unsigned seq;
    int unsigned areg;
    int unsigned newp;
    int unsigned oldp;
    bit          ph;
  } ent_t;

  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0, hold_valid = 0, commit_valid = 0, squash_valid = 0;
  logic [SEQ_W-1:0] alloc_seq = 0, hold_seq = 0, commit_seq = 0, squash_seq = 0;
  logic [AREG_W-1:0] alloc_areg = 0;
  logic [PREG_W-1:0] alloc_new_preg = 0, alloc_old_preg = 0;
  logic insert_ready, free_valid, restore_valid, busy, log_full, log_empty;
  logic [PREG_W-1:0] free_preg, restore_preg;
  logic [AREG_W-1:0] restore_areg;
  logic [CNT_W-1:0] cnt_commit_maps, cnt_undo_maps, cnt_undo_real, cnt_holds;

  int checks = 0, bad = 0;
  ent_t mdl[$];
  int unsigned x_commit = 0, x_undo = 0, x_undo_real = 0, x_holds = 0;
  int unsigned next_seq = 1;

  always #2.5 clk = ~clk;

  rename_history_buf #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .AREG_W(AREG_W),
    .PREG_W(PREG_W), .CNT_W(CNT_W)) i_rename_history_buf (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .alloc_areg(alloc_areg),
    .alloc_new_preg(alloc_new_preg), .alloc_old_preg(alloc_old_preg),
    .hold_valid(hold_valid), .hold_seq(hold_seq), .insert_ready(insert_ready),
    .commit_valid(commit_valid), .commit_seq(commit_seq),
    .squash_valid(squash_valid), .squash_seq(squash_seq),
    .free_valid(free_valid), .free_preg(free_preg),
    .restore_valid(restore_valid), .restore_areg(restore_areg),
    .restore_preg(restore_preg), .busy(busy), .log_full(log_full),
    .log_empty(log_empty), .cnt_commit_maps(cnt_commit_maps),
    .cnt_undo_maps(cnt_undo_maps), .cnt_undo_real(cnt_undo_real),
    .cnt_holds(cnt_holds));

  task automatic chk(input bit ok, input string tag, input int unsigned act,
                     input int unsigned exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_ready();
    return mdl.size() < DEPTH;
  endfunction

  function automatic bit commit_takes(int unsigned lim);
    return mdl.size() > 0 && mdl[0].seq <= lim;
  endfunction

  function automatic bit squash_takes(int unsigned lim);
    return mdl.size() > 0 && mdl[mdl.size()-1].seq > lim;
  endfunction

  // inserts one entry; kind 0 real, 1 marker, 2 both valid (real wins)
  task automatic do_insert(input int kind);
    ent_t e;
    bit rdy;
    @(negedge clk);
    rdy = exp_ready();
    chk(insert_ready == rdy, "R2/R3 insert_ready", insert_ready, rdy);
    e.seq = next_seq; e.areg = $urandom_range(31);
    e.newp = $urandom_range(63); e.oldp = $urandom_range(63);
    e.ph = (kind == 1);
    alloc_valid = (kind != 1); hold_valid = (kind != 0);
    alloc_seq = SEQ_W'(e.seq); hold_seq = SEQ_W'(e.seq);
    alloc_areg = AREG_W'(e.areg); alloc_new_preg = PREG_W'(e.newp);
    alloc_old_preg = PREG_W'(e.oldp);
    @(posedge clk);
    if (rdy) begin
      mdl.push_back(e);
      if (e.ph) x_holds++;
      next_seq++;
    end
    #1;
    alloc_valid = 0; hold_valid = 0;
  endtask

  // one walk; inj: 0 none, 1 commit mid-walk, 2 squash mid-walk
  task automatic do_walk(input bit is_sq, input int unsigned lim,
                         input int inj, input int unsigned inj_lim);
    bit cur_sq = is_sq;
    int unsigned cur_lim = lim;
    bit injected = 0;
    bit q;
    @(negedge clk);
    if (is_sq) begin squash_valid = 1; squash_seq = SEQ_W'(lim); end
    else begin commit_valid = 1; commit_seq = SEQ_W'(lim); end
    @(posedge clk); #1;
    squash_valid = 0; commit_valid = 0;
    for (int step = 0; step < 4 * DEPTH + 8; step++) begin
      @(negedge clk);
      chk(busy == 1, "R8 busy during walk", busy, 1);
      q = cur_sq ? squash_takes(cur_lim) : commit_takes(cur_lim);
      if (!q) begin
        chk(free_valid == 0, "R4/R10 no return at walk end", free_valid, 0);
        chk(restore_valid == 0, "R5 no restore at walk end", restore_valid, 0);
        @(negedge clk);
        chk(busy == 0, "R4 busy falls", busy, 0);
        return;
      end
      if (cur_sq) begin
        ent_t e = mdl.pop_back();
        x_undo++;
        chk(free_valid == !e.ph, "R5/R6 squash free_valid", free_valid, !e.ph);
        chk(restore_valid == !e.ph, "R5/R6 restore_valid", restore_valid, !e.ph);
        if (!e.ph) begin
          x_undo_real++;
          chk(free_preg == e.newp, "R5 free new preg", free_preg, e.newp);
          chk(restore_areg == e.areg, "R5 restore areg", restore_areg, e.areg);
          chk(restore_preg == e.oldp, "R5 restore preg", restore_preg, e.oldp);
        end
      end else begin
        ent_t e = mdl.pop_front();
        chk(free_valid == !e.ph, "R4/R6 commit free_valid", free_valid, !e.ph);
        chk(restore_valid == 0, "R4 no restore on commit", restore_valid, 0);
        if (!e.ph) begin
          x_commit++;
          chk(free_preg == e.oldp, "R4 free old preg", free_preg, e.oldp);
        end
      end
      if (inj != 0 && !injected) begin
        injected = 1;
        if (inj == 1) begin commit_valid = 1; commit_seq = SEQ_W'(inj_lim); end
        else begin squash_valid = 1; squash_seq = SEQ_W'(inj_lim); end
        @(posedge clk); #1;
        commit_valid = 0; squash_valid = 0;
        // R7: mid-walk commit dropped; squash takes over a commit walk
        if (inj == 2 && !cur_sq) begin cur_sq = 1; cur_lim = inj_lim; end
      end
    end
    chk(0, "R10 walk did not end", 0, 1);
  endtask

  task automatic chk_counters(input string where);
    @(negedge clk);
    chk(cnt_commit_maps == x_commit, {"R9 commit maps ", where}, cnt_commit_maps, x_commit);
    chk(cnt_undo_maps == x_undo, {"R9 undo maps ", where}, cnt_undo_maps, x_undo);
    chk(cnt_undo_real == x_undo_real, {"R9 undo real ", where}, cnt_undo_real, x_undo_real);
    chk(cnt_holds == x_holds, {"R9 holds ", where}, cnt_holds, x_holds);
    chk(log_empty == (mdl.size() == 0), {"R10 empty flag ", where}, log_empty, mdl.size() == 0);
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    bad++; checks++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = $urandom(32'h5eed1234);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(log_empty == 1, "R1 empty", log_empty, 1);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(free_valid == 0 && restore_valid == 0, "R1 outputs", free_valid, 0);
    chk(insert_ready == 1, "R1 ready", insert_ready, 1);
    chk_counters("R1 reset");

    // directed: mixed entries, commit landing exactly on an entry
    do_insert(0); do_insert(1); do_insert(0); do_insert(2); do_insert(0);
    do_walk(0, 3, 0, 0);          // R4 inclusive done number, R6 marker
    chk_counters("after commit");
    do_walk(1, 4, 0, 0);          // R5 undo only seq 5
    chk_counters("after squash");

    // directed: fill to full, R3
    while (mdl.size() < DEPTH) do_insert(($urandom_range(3) == 0) ? 1 : 0);
    @(negedge clk);
    chk(log_full == 1, "R3 full flag", log_full, 1);
    do_insert(0);                 // refused, model unchanged
    do_insert(1);
    chk_counters("full");
    // drain all through commit: R10 stop at empty
    do_walk(0, 16'hFFFF, 0, 0);
    chk_counters("drain commit");

    // R7: commit dropped during squash walk
    repeat (6) do_insert(0);
    do_walk(1, mdl[1].seq, 1, 16'hFFFF);
    chk_counters("commit during squash");
    // R7: squash during commit walk
    repeat (5) do_insert(($urandom_range(2) == 0) ? 1 : 0);
    do_walk(0, 16'hFFFF, 2, mdl[3].seq);
    chk_counters("squash during commit");
    do_walk(1, 0, 0, 0);          // R5 drain all by squash
    chk_counters("drain squash");

    // random phase
    for (int r = 0; r < 300; r++) begin
      int n = $urandom_range(DEPTH);
      for (int k = 0; k < n; k++) do_insert($urandom_range(2));
      if (mdl.size() > 0) begin
        int unsigned lo = mdl[0].seq;
        int unsigned hi = mdl[mdl.size()-1].seq;
        int unsigned lim = $urandom_range(hi + 1, (lo > 0) ? lo - 1 : 0);
        int inj = ($urandom_range(7) == 0) ? int'($urandom_range(2, 1)) : 0;
        do_walk($urandom_range(1), lim, inj, lim);
      end
      if (r % 25 == 0) chk_counters("random");
    end
    chk_counters("final");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule